// File: doc/BRIEF.md
# SDRAM Burst Column and Data-Phase Scheduler

This block sits behind the command sequencer of an SDRAM controller. Once a column command (read or write) has been placed on the command bus, the scheduler produces the column address of every beat of the burst. It drives the data-bus enable for write beats and flags the cycles in which read data should be captured. It also produces the byte-mask pins with the latency that each direction needs. Burst length, burst order, CAS latency and the single-write mode come from configuration inputs that mirror the mode register.

A burst ends on its own after its programmed length. It ends early on a burst stop, on a precharge that hits its bank, or on a new column command, which starts the next burst in the same cycle. Page-length bursts wrap around the page and run until one of those events. For bursts that finish naturally with auto precharge requested, the scheduler reports the cycle in which the bank may start precharging.

Top module: `sdr_burst_sched`

## Requirements
- R1: After synchronous reset, no beat is issued, the data enable is low, no read capture is flagged, no auto-precharge pulse is given, and all mask bits are high.
- R2: The length code `cfg_bl` selects the number of beats: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a page burst. Codes 4, 5 and 6 give 1.
- R3: In sequential order, beat n has the start column with its low log2(L) bits replaced by (start + n) mod L, where L is the burst length.
- R4: In interleaved order (`cfg_interleave`=1, latched at the command), the low log2(L) bits of beat n are the start bits XOR n. Page bursts ignore this input and always count sequentially.
- R5: A page burst continues beat by beat and wraps from the last column of the page to column 0. It ends only on stop, on a precharge to its bank, or on a new column command. It never produces an auto-precharge pulse.
- R6: The first beat of a burst, with `beat_col` equal to the command's column, appears in the same cycle as the command. For a write, `dq_oe` is high in every write beat and low otherwise.
- R7: A read beat issued in cycle c raises `rd_capture` in cycle c + `cfg_cas_lat` (2 or 3), with `rd_col` equal to that beat's column.
- R8: In a write beat, `dqm` equals `beat_mask` of that same cycle. Otherwise, `dqm` in cycle t equals the `beat_mask` given with the read beat whose data appears in cycle t+2. When there is no such beat, all bits of `dqm` are high.
- R9: With `cfg_single_wr`=1, every write burst is one beat long, while read bursts keep the programmed length.
- R10: A column command arriving during a burst ends that burst and issues the new burst's first beat in the same cycle. Its later beats follow from the new start column.
- R11: A burst stop issues no beat in its own cycle or after it. Read beats issued before the stop are still captured.
- R12: A precharge to the burst's bank, or to all banks, ends the burst like a stop, so no further write beat is driven and the mask stays high. A precharge to another bank has no effect on the burst.
- R13: A write beat cancels the capture of every read beat still in flight, both in that cycle and in later cycles.
- R14: When a burst that is not a page burst and was issued with auto precharge completes its last beat, `ap_start` pulses in the next cycle with `ap_bank` set to the burst's bank. Interrupted bursts give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bl | input | 3 | Burst length code |
| cfg_interleave | input | 1 | Interleaved column order |
| cfg_cas_lat | input | 2 | Read latency in cycles (2..CL_MAX) |
| cfg_single_wr | input | 1 | Force write bursts to one beat |
| col_cmd_vld | input | 1 | Column command issued this cycle |
| col_cmd_wr | input | 1 | Command is a write |
| col_cmd_ap | input | 1 | Command carries auto precharge |
| col_cmd_bank | input | BANK_W | Command bank |
| col_cmd_col | input | COL_W | Start column |
| stop_cmd | input | 1 | Burst stop issued this cycle |
| pre_cmd | input | 1 | Precharge issued this cycle |
| pre_all | input | 1 | Precharge covers all banks |
| pre_bank | input | BANK_W | Precharged bank |
| beat_mask | input | DQM_W | Byte mask for the beat of this cycle |
| beat_vld | output | 1 | A burst beat occupies this cycle |
| beat_wr | output | 1 | Current beat is a write |
| beat_bank | output | BANK_W | Bank of the current beat |
| beat_col | output | COL_W | Column of the current beat |
| dq_oe | output | 1 | Drive the data bus with write data |
| dqm | output | DQM_W | Mask pins |
| rd_capture | output | 1 | Capture read data this cycle |
| rd_col | output | COL_W | Column of the captured read data |
| ap_start | output | 1 | Auto precharge may begin |
| ap_bank | output | BANK_W | Bank for auto precharge |

## Verification
The bench aims at the column order at block boundaries, such as a start column near the top of an aligned group and wrap at the last page column. A wrong mask or a wrong count would send beats outside the group, or would stop a page burst at its length field. The read mask must come out cl-2 cycles after the beat, while the write mask takes effect at once. An off-by-one delay shows up as a mask on the neighbouring beat. The bench also covers write-after-read cancellation, precharge to a foreign bank, and forced single writes. A design that got these wrong would capture stale data under a write, end a burst that should continue, or issue extra write beats.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    // Burst length codes; values match the mode register field the sequencer writes.
    typedef enum logic [2:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd7
    } burst_len_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } burst_kind_e;

    localparam int LEN_LOG_W = 2;

    // log2 of the fixed burst length; reserved codes map to one beat.
    function automatic logic [LEN_LOG_W-1:0] bl_log2(input logic [2:0] code);
        case (code)
            3'd1:    return 2'd1;
            3'd2:    return 2'd2;
            3'd3:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0]     start_col,
    input  logic [COL_W-1:0]     beat_idx,
    input  logic [LEN_LOG_W-1:0] len_log,
    input  logic                 page_mode,
    input  logic                 interleave,
    output logic [COL_W-1:0]     col
);
    localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

    logic [COL_W-1:0] grp_mask;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;
    logic [COL_W-1:0] low_bits;

    always_comb begin
        grp_mask = page_mode ? {COL_W{1'b1}} : ((ONE << len_log) - ONE);
        seq_col  = start_col + beat_idx;
        xor_col  = start_col ^ beat_idx;
        low_bits = (interleave && !page_mode) ? xor_col : seq_col;
        col      = (start_col & ~grp_mask) | (low_bits & grp_mask);
    end

endmodule

// File: rtl/sdr_burst_ctl.sv
module sdr_burst_ctl
    import sdr_burst_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_bl,
    input  logic              cfg_il,
    input  logic              cfg_single_wr,
    input  logic              cmd_vld,
    input  logic              cmd_wr,
    input  logic              cmd_ap,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              stop_cmd,
    input  logic              pre_cmd,
    input  logic              pre_all,
    input  logic [BANK_W-1:0] pre_bank,
    output logic              beat_vld,
    output logic              beat_wr,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col,
    output logic              ap_start,
    output logic [BANK_W-1:0] ap_bank
);
    localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

    burst_kind_e            kind_q, kind_d;
    logic [BANK_W-1:0]      bank_q, bank_d;
    logic [COL_W-1:0]       start_q, start_d;
    logic [COL_W-1:0]       cnt_q, cnt_d;
    logic [LEN_LOG_W-1:0]   log_q, log_d;
    logic                   page_q, page_d;
    logic                   il_q, il_d;
    logic                   ap_q, ap_d;
    logic                   aps_q, aps_d;
    logic [BANK_W-1:0]      apb_q, apb_d;

    logic                   pre_hit, cont, last, force_one, new_page, cmd_one;
    logic [LEN_LOG_W-1:0]   new_log;
    logic [COL_W-1:0]       last_cnt;
    logic [COL_W-1:0]       g_start, g_cnt;
    logic [LEN_LOG_W-1:0]   g_log;
    logic                   g_page, g_il;

    always_comb begin
        pre_hit   = pre_cmd && (pre_all || (pre_bank == bank_q));
        cont      = (kind_q != KIND_NONE) && !cmd_vld && !stop_cmd && !pre_hit;
        last_cnt  = (ONE << log_q) - ONE;
        last      = cont && !page_q && (cnt_q == last_cnt);
        force_one = cmd_wr && cfg_single_wr;
        new_page  = (cfg_bl == BL_PAGE) && !force_one;
        new_log   = force_one ? '0 : bl_log2(cfg_bl);
        cmd_one   = !new_page && (new_log == '0);
    end

    always_comb begin
        g_start = cmd_vld ? cmd_col  : start_q;
        g_cnt   = cmd_vld ? '0       : cnt_q;
        g_log   = cmd_vld ? new_log  : log_q;
        g_page  = cmd_vld ? new_page : page_q;
        g_il    = cmd_vld ? cfg_il   : il_q;
    end

    sdr_burst_colgen #(.COL_W(COL_W)) colgen_i (
        .start_col (g_start),
        .beat_idx  (g_cnt),
        .len_log   (g_log),
        .page_mode (g_page),
        .interleave(g_il),
        .col       (beat_col)
    );

    always_comb begin
        beat_vld  = cmd_vld || cont;
        beat_wr   = cmd_vld ? cmd_wr : (cont && (kind_q == KIND_WRITE));
        beat_bank = cmd_vld ? cmd_bank : bank_q;
        ap_start  = aps_q;
        ap_bank   = apb_q;
    end

    always_comb begin
        kind_d  = kind_q;
        bank_d  = bank_q;
        start_d = start_q;
        cnt_d   = cnt_q;
        log_d   = log_q;
        page_d  = page_q;
        il_d    = il_q;
        ap_d    = ap_q;
        aps_d   = 1'b0;
        apb_d   = apb_q;
        if (cmd_vld) begin
            kind_d  = cmd_one ? KIND_NONE : (cmd_wr ? KIND_WRITE : KIND_READ);
            bank_d  = cmd_bank;
            start_d = cmd_col;
            cnt_d   = ONE;
            log_d   = new_log;
            page_d  = new_page;
            il_d    = cfg_il;
            ap_d    = cmd_ap && !new_page;
            aps_d   = cmd_one && cmd_ap;
            apb_d   = cmd_bank;
        end else if (cont) begin
            cnt_d = cnt_q + ONE;
            if (last) begin
                kind_d = KIND_NONE;
                aps_d  = ap_q;
                apb_d  = bank_q;
            end
        end else if (kind_q != KIND_NONE) begin
            kind_d = KIND_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= KIND_NONE;
            bank_q  <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            log_q   <= '0;
            page_q  <= 1'b0;
            il_q    <= 1'b0;
            ap_q    <= 1'b0;
            aps_q   <= 1'b0;
            apb_q   <= '0;
        end else begin
            kind_q  <= kind_d;
            bank_q  <= bank_d;
            start_q <= start_d;
            cnt_q   <= cnt_d;
            log_q   <= log_d;
            page_q  <= page_d;
            il_q    <= il_d;
            ap_q    <= ap_d;
            aps_q   <= aps_d;
            apb_q   <= apb_d;
        end
    end

    // R9: a forced single write leaves no burst running behind it
    assert_single_wr_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd_wr && cfg_single_wr) |=> (kind_q == KIND_NONE));

    // R11: a stop without a new command ends the running burst
    assert_stop_ends_R11: assert property (@(posedge clk) disable iff (rst)
        (stop_cmd && !cmd_vld) |=> (kind_q == KIND_NONE));

    // R12: a precharge aimed at another bank does not cut the burst
    assert_pre_other_R12: assert property (@(posedge clk) disable iff (rst)
        ((kind_q != KIND_NONE) && pre_cmd && !pre_all && (pre_bank != bank_q)
         && !stop_cmd && !cmd_vld) |-> beat_vld);

    // R5: a page burst never carries a pending auto precharge
    assert_page_no_ap_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && (cfg_bl == BL_PAGE) && !(cmd_wr && cfg_single_wr)) |=> !ap_q);

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int COL_W  = 8,
    parameter int DQM_W  = 4,
    parameter int CL_MAX = 3,
    localparam int CLW   = $clog2(CL_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CLW-1:0]   cfg_cl,
    input  logic             rd_beat,
    input  logic             wr_beat,
    input  logic [COL_W-1:0] beat_col,
    input  logic [DQM_W-1:0] beat_mask,
    output logic             rd_capture,
    output logic [COL_W-1:0] rd_col,
    output logic             rd_dqm_vld,
    output logic [DQM_W-1:0] rd_dqm
);
    logic [CL_MAX:1]  vld_q;
    logic [COL_W-1:0] col_q [1:CL_MAX];
    logic [DQM_W-1:0] msk_q [1:CL_MAX];

    logic             v_all [0:CL_MAX];
    logic [COL_W-1:0] c_all [0:CL_MAX];
    logic [DQM_W-1:0] m_all [0:CL_MAX];
    logic [CLW-1:0]   cl_eff;
    logic [CLW-1:0]   dqm_idx;

    always_ff @(posedge clk) begin
        if (rst || wr_beat) begin
            vld_q <= '0;
        end else begin
            vld_q[1] <= rd_beat;
            for (int k = 2; k <= CL_MAX; k++) begin
                vld_q[k] <= vld_q[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        col_q[1] <= beat_col;
        msk_q[1] <= beat_mask;
        for (int k = 2; k <= CL_MAX; k++) begin
            col_q[k] <= col_q[k-1];
            msk_q[k] <= msk_q[k-1];
        end
    end

    always_comb begin
        v_all[0] = rd_beat;
        c_all[0] = beat_col;
        m_all[0] = beat_mask;
        for (int k = 1; k <= CL_MAX; k++) begin
            v_all[k] = vld_q[k];
            c_all[k] = col_q[k];
            m_all[k] = msk_q[k];
        end
        if (cfg_cl < CLW'(2))
            cl_eff = CLW'(2);
        else if (cfg_cl > CLW'(CL_MAX))
            cl_eff = CLW'(CL_MAX);
        else
            cl_eff = cfg_cl;
        dqm_idx    = cl_eff - CLW'(2);
        rd_capture = v_all[cl_eff] && !wr_beat;
        rd_col     = c_all[cl_eff];
        rd_dqm_vld = v_all[dqm_idx];
        rd_dqm     = m_all[dqm_idx];
    end

    // R13: after a write beat no read beat remains in flight
    assert_wr_cancel_R13: assert property (@(posedge clk) disable iff (rst)
        wr_beat |=> (vld_q == '0));

endmodule

// File: rtl/sdr_burst_sched.sv
module sdr_burst_sched #(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int DQM_W  = 4,
    parameter int CL_MAX = 3,
    localparam int CLW   = $clog2(CL_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_bl,
    input  logic              cfg_interleave,
    input  logic [CLW-1:0]    cfg_cas_lat,
    input  logic              cfg_single_wr,
    input  logic              col_cmd_vld,
    input  logic              col_cmd_wr,
    input  logic              col_cmd_ap,
    input  logic [BANK_W-1:0] col_cmd_bank,
    input  logic [COL_W-1:0]  col_cmd_col,
    input  logic              stop_cmd,
    input  logic              pre_cmd,
    input  logic              pre_all,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic [DQM_W-1:0]  beat_mask,
    output logic              beat_vld,
    output logic              beat_wr,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col,
    output logic              dq_oe,
    output logic [DQM_W-1:0]  dqm,
    output logic              rd_capture,
    output logic [COL_W-1:0]  rd_col,
    output logic              ap_start,
    output logic [BANK_W-1:0] ap_bank
);
    logic             wr_beat, rd_beat, rd_dqm_vld;
    logic [DQM_W-1:0] rd_dqm;

    sdr_burst_ctl #(.COL_W(COL_W), .BANK_W(BANK_W)) ctl_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_bl       (cfg_bl),
        .cfg_il       (cfg_interleave),
        .cfg_single_wr(cfg_single_wr),
        .cmd_vld      (col_cmd_vld),
        .cmd_wr       (col_cmd_wr),
        .cmd_ap       (col_cmd_ap),
        .cmd_bank     (col_cmd_bank),
        .cmd_col      (col_cmd_col),
        .stop_cmd     (stop_cmd),
        .pre_cmd      (pre_cmd),
        .pre_all      (pre_all),
        .pre_bank     (pre_bank),
        .beat_vld     (beat_vld),
        .beat_wr      (beat_wr),
        .beat_bank    (beat_bank),
        .beat_col     (beat_col),
        .ap_start     (ap_start),
        .ap_bank      (ap_bank)
    );

    always_comb begin
        wr_beat = beat_vld && beat_wr;
        rd_beat = beat_vld && !beat_wr;
    end

    sdr_rd_pipe #(.COL_W(COL_W), .DQM_W(DQM_W), .CL_MAX(CL_MAX)) pipe_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_cl    (cfg_cas_lat),
        .rd_beat   (rd_beat),
        .wr_beat   (wr_beat),
        .beat_col  (beat_col),
        .beat_mask (beat_mask),
        .rd_capture(rd_capture),
        .rd_col    (rd_col),
        .rd_dqm_vld(rd_dqm_vld),
        .rd_dqm    (rd_dqm)
    );

    always_comb begin
        dq_oe = wr_beat;
        if (wr_beat)
            dqm = beat_mask;
        else if (rd_dqm_vld)
            dqm = rd_dqm;
        else
            dqm = '1;
    end

    // R6: a write command drives the bus with its own column in the same cycle
    assert_wr_first_beat_R6: assert property (@(posedge clk) disable iff (rst)
        (col_cmd_vld && col_cmd_wr) |-> (dq_oe && (beat_col == col_cmd_col)));

endmodule

// File: tb/sdr_burst_sched_tb.sv
module sdr_burst_sched_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_bl = 3'd2;
    logic       cfg_interleave = 1'b0;
    logic [1:0] cfg_cas_lat = 2'd2;
    logic       cfg_single_wr = 1'b0;
    logic       col_cmd_vld = 1'b0, col_cmd_wr = 1'b0, col_cmd_ap = 1'b0;
    logic [1:0] col_cmd_bank = '0;
    logic [7:0] col_cmd_col = '0;
    logic       stop_cmd = 1'b0, pre_cmd = 1'b0, pre_all = 1'b0;
    logic [1:0] pre_bank = '0;
    logic [3:0] beat_mask = '0;
    logic       beat_vld, beat_wr, dq_oe, rd_capture, ap_start;
    logic [1:0] beat_bank, ap_bank;
    logic [7:0] beat_col, rd_col;
    logic [3:0] dqm;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_burst_sched dut_i (
        .clk(clk), .rst(rst), .cfg_bl(cfg_bl), .cfg_interleave(cfg_interleave),
        .cfg_cas_lat(cfg_cas_lat), .cfg_single_wr(cfg_single_wr),
        .col_cmd_vld(col_cmd_vld), .col_cmd_wr(col_cmd_wr), .col_cmd_ap(col_cmd_ap),
        .col_cmd_bank(col_cmd_bank), .col_cmd_col(col_cmd_col),
        .stop_cmd(stop_cmd), .pre_cmd(pre_cmd), .pre_all(pre_all), .pre_bank(pre_bank),
        .beat_mask(beat_mask), .beat_vld(beat_vld), .beat_wr(beat_wr),
        .beat_bank(beat_bank), .beat_col(beat_col), .dq_oe(dq_oe), .dqm(dqm),
        .rd_capture(rd_capture), .rd_col(rd_col), .ap_start(ap_start), .ap_bank(ap_bank)
    );

    // reference state, derived from the requirements
    int m_kind = 0;  // 0 idle, 1 read, 2 write
    int m_bank = 0, m_start = 0, m_cnt = 0, m_log = 0;
    bit m_page = 0, m_il = 0, m_ap = 0, m_aps = 0;
    int m_apb = 0;
    bit hv [1:3];
    int hc [1:3];
    int hm [1:3];

    function automatic int len_log(input int code);
        if (code >= 1 && code <= 3) return code;
        return 0;
    endfunction

    function automatic int ref_col(input int s, input int n, input int lg, input bit pg, input bit il);
        int msk;
        if (pg) return (s + n) & 255;
        msk = (1 << lg) - 1;
        if (il) return (s & ~msk & 255) | ((s ^ n) & msk);
        return (s & ~msk & 255) | ((s + n) & msk);
    endfunction

    task automatic chk(input string ph, input string rq, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", ph, rq, got, exp, $time);
        end
    endtask

    task automatic tick(input string ph);
        int e_beat = 0, e_wr = 0, e_col = 0, e_bank = 0, e_dqm, cl;
        bit pre_hit, cont, force1, npage, rd_now, e_oe, e_cap, last;
        int nlog;
        #3;
        cl = int'(cfg_cas_lat);
        pre_hit = pre_cmd && (pre_all || int'(pre_bank) == m_bank);
        cont = (m_kind != 0) && !col_cmd_vld && !stop_cmd && !pre_hit;
        force1 = col_cmd_wr && cfg_single_wr;
        npage = (cfg_bl == 3'd7) && !force1;
        nlog = force1 ? 0 : len_log(int'(cfg_bl));
        if (col_cmd_vld) begin
            e_beat = 1; e_wr = col_cmd_wr; e_col = col_cmd_col; e_bank = col_cmd_bank;
        end else if (cont) begin
            e_beat = 1; e_wr = (m_kind == 2);
            e_col = ref_col(m_start, m_cnt, m_log, m_page, m_il); e_bank = m_bank;
        end
        e_oe = e_beat && e_wr;
        rd_now = e_beat && !e_wr;
        e_cap = hv[cl] && !e_oe;
        if (e_oe) e_dqm = beat_mask;
        else if (cl == 2 && rd_now) e_dqm = beat_mask;
        else if (cl == 3 && hv[1]) e_dqm = hm[1];
        else e_dqm = 15;

        chk(ph, "R2 beat_vld", beat_vld, e_beat);
        chk(ph, "R10 beat_wr", beat_wr, e_wr);
        if (e_beat) begin
            chk(ph, "R3 beat_col", beat_col, e_col);
            chk(ph, "R10 beat_bank", beat_bank, e_bank);
        end
        chk(ph, "R6 dq_oe", dq_oe, e_oe);
        chk(ph, "R8 dqm", dqm, e_dqm);
        chk(ph, "R7 rd_capture", rd_capture, e_cap);
        if (e_cap) chk(ph, "R7 rd_col", rd_col, hc[cl]);
        chk(ph, "R14 ap_start", ap_start, m_aps);
        if (m_aps) chk(ph, "R14 ap_bank", ap_bank, m_apb);

        // advance the reference one clock
        hv[3] = hv[2]; hc[3] = hc[2]; hm[3] = hm[2];
        hv[2] = hv[1]; hc[2] = hc[1]; hm[2] = hm[1];
        hv[1] = rd_now; hc[1] = e_col; hm[1] = beat_mask;
        if (e_oe) begin hv[1] = 0; hv[2] = 0; hv[3] = 0; end
        last = cont && !m_page && (m_cnt == (1 << m_log) - 1);
        m_aps = 0;
        if (col_cmd_vld) begin
            m_kind = (!npage && nlog == 0) ? 0 : (col_cmd_wr ? 2 : 1);
            m_bank = col_cmd_bank; m_start = col_cmd_col; m_cnt = 1;
            m_log = nlog; m_page = npage; m_il = cfg_interleave;
            m_ap = col_cmd_ap && !npage;
            m_aps = (!npage && nlog == 0) && col_cmd_ap; m_apb = col_cmd_bank;
        end else if (cont) begin
            m_cnt = (m_cnt + 1) & 255;
            if (last) begin m_kind = 0; m_aps = m_ap; m_apb = m_bank; end
        end else begin
            m_kind = 0;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        col_cmd_vld = 0; col_cmd_wr = 0; col_cmd_ap = 0;
        stop_cmd = 0; pre_cmd = 0; pre_all = 0;
    endtask

    task automatic issue(input bit wr, input int bank, input int col, input bit ap, input string ph);
        col_cmd_vld = 1; col_cmd_wr = wr; col_cmd_bank = 2'(bank);
        col_cmd_col = 8'(col); col_cmd_ap = ap;
        beat_mask = 4'($urandom_range(0, 15));
        tick(ph);
        quiet();
    endtask

    task automatic idle(input int n, input string ph);
        for (int i = 0; i < n; i++) begin
            beat_mask = 4'($urandom_range(0, 15));
            tick(ph);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5d2a_91c7));
        for (int d = 1; d <= 3; d++) begin hv[d] = 0; hc[d] = 0; hm[d] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state seen on the first idle cycles
        idle(2, "R1");

        // R2: each length code, including a reserved one
        for (int c = 0; c < 5; c++) begin
            cfg_bl = 3'(c);
            issue(0, 1, 8'h35, 0, "R2");
            idle(11, "R2");
        end
        cfg_bl = 3'd6; issue(1, 0, 8'h12, 0, "R2"); idle(3, "R2");

        // R3 sequential, R4 interleaved, start near top of a group
        cfg_bl = 3'd3; cfg_interleave = 0; issue(0, 2, 8'h3E, 0, "R3"); idle(11, "R3");
        cfg_interleave = 1; issue(0, 2, 8'h3E, 0, "R4"); idle(11, "R4");
        cfg_bl = 3'd2; issue(1, 2, 8'h85, 0, "R4"); idle(6, "R4");

        // R5: page burst wraps past column 255, auto precharge dropped, page ignores interleave
        cfg_bl = 3'd7; issue(0, 3, 8'hFC, 1, "R5"); idle(262, "R5");
        stop_cmd = 1; tick("R5"); quiet(); idle(5, "R5");
        cfg_interleave = 0;

        // R6 / R8: write beats with masks, CAS latency 3 read masks
        cfg_bl = 3'd2; issue(1, 1, 8'h40, 0, "R6"); idle(5, "R8");
        cfg_cas_lat = 2'd3; issue(0, 1, 8'h50, 0, "R8"); idle(7, "R7");
        cfg_cas_lat = 2'd2; issue(0, 1, 8'h60, 0, "R7"); idle(6, "R7");

        // R9: single-write mode
        cfg_single_wr = 1; cfg_bl = 3'd3;
        issue(1, 0, 8'h10, 1, "R9"); idle(3, "R9");
        issue(0, 0, 8'h10, 0, "R9"); idle(10, "R9");
        cfg_bl = 3'd7; issue(1, 0, 8'h20, 0, "R9"); idle(3, "R9");
        cfg_single_wr = 0; cfg_bl = 3'd3;

        // R10: interrupt by read, then by write (R13 cancels pending reads)
        issue(0, 0, 8'h00, 1, "R10"); idle(2, "R10");
        issue(0, 1, 8'h23, 0, "R10"); idle(2, "R10");
        issue(1, 2, 8'h70, 0, "R13"); idle(10, "R13");

        // R11: stop mid read keeps earlier captures
        cfg_cas_lat = 2'd3;
        issue(0, 0, 8'h08, 0, "R11"); idle(2, "R11");
        stop_cmd = 1; tick("R11"); quiet(); idle(6, "R11");

        // R12: precharge to other bank, same bank, all banks
        issue(1, 1, 8'h90, 0, "R12"); idle(1, "R12");
        pre_cmd = 1; pre_bank = 2'd3; tick("R12"); quiet(); idle(1, "R12");
        pre_cmd = 1; pre_bank = 2'd1; tick("R12"); quiet(); idle(4, "R12");
        issue(0, 2, 8'hA0, 0, "R12"); idle(1, "R12");
        pre_cmd = 1; pre_all = 1; pre_bank = 2'd0; tick("R12"); quiet(); idle(6, "R12");

        // R14: completed burst with auto precharge
        cfg_bl = 3'd1; issue(1, 3, 8'h33, 1, "R14"); idle(4, "R14");
        cfg_bl = 3'd0; issue(0, 2, 8'h34, 1, "R14"); idle(4, "R14");

        // random traffic, configuration changes only while idle
        for (int blk = 0; blk < 10; blk++) begin
            idle(6, "RND");
            begin
                int pick = $urandom_range(0, 5);
                cfg_bl = (pick == 4) ? 3'd7 : (pick == 5) ? 3'd5 : 3'(pick);
            end
            cfg_cas_lat = 2'($urandom_range(2, 3));
            cfg_single_wr = 1'($urandom_range(0, 1));
            for (int i = 0; i < 400; i++) begin
                int r = $urandom_range(0, 99);
                cfg_interleave = 1'($urandom_range(0, 1));
                beat_mask = 4'($urandom_range(0, 15));
                quiet();
                if (r < 15) begin
                    col_cmd_vld = 1; col_cmd_wr = 1'($urandom_range(0, 1));
                    col_cmd_ap = 1'($urandom_range(0, 1));
                    col_cmd_bank = 2'($urandom_range(0, 3));
                    col_cmd_col = 8'($urandom_range(0, 255));
                end else if (r < 19) begin
                    stop_cmd = 1;
                end else if (r < 25) begin
                    pre_cmd = 1; pre_all = ($urandom_range(0, 3) == 0);
                    pre_bank = 2'($urandom_range(0, 3));
                end
                tick("RND");
            end
            quiet();
        end
        idle(6, "RND");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule